// File: doc/BRIEF.md
# Packed SIMD Rotate-Right Unit

This block is the datapath of one 64-bit lane of a vector unit. It splits a packed data word into elements of a run-time width of 8, 16, 32 or 64 bits. It rotates each element to the right by an amount taken from the matching element of a second packed word. Bits that leave the low end of an element come back in at its high end, so no bits are lost. The result element always has the same width as the source element.

Only active body elements receive the rotated value. An element is in the body when its global index lies in the range [start, length). The global index is a base index for the lane plus the element's position in the word. When masking is enabled, an element also needs its mask bit set to be active. Every other element keeps the value of the old destination word.

The result is registered one cycle after an input pulse and is flagged by a one-cycle valid.

Top module: `simd_ror`

## Requirements
- R1: Each active element is rotated right within its own boundaries. The result bit k of an element of width W is source bit (k + a) mod W of that element, and no bits are lost or taken from a neighbouring element.
- R2: The rotated value comes from `data_i`. The matching element of `amt_i` supplies only the rotate amount.
- R3: Only the low log2(W) bits of each amount element are used: 3, 4, 5 or 6 bits for W = 8, 16, 32 or 64. Higher amount bits have no effect on the result.
- R4: `sew_i` selects the element width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. Element i occupies bits [i*W +: W], and each result element is W bits wide.
- R5: When `mask_en_i` is 1, element i is active only if `mask_i[i]` is 1. When `mask_en_i` is 0, every body element is active and `mask_i` is ignored.
- R6: Element i is in the body only when its index `base_i + i` satisfies `vstart_i <= base_i + i < vl_i`.
- R7: An inactive element takes the bits of `old_i` at the same position.
- R8: An active element whose truncated amount is zero comes out equal to its source element.
- R9: `valid_o` is 1 in exactly the cycle after a cycle with `valid_i` = 1, and 0 otherwise. `result_o` changes only when `valid_o` is 1.
- R10: After reset, `valid_o` is 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operands are valid |
| data_i | input | 64 | Packed elements to rotate |
| amt_i | input | 64 | Packed per-element rotate amounts |
| old_i | input | 64 | Old destination word, kept for inactive elements |
| mask_i | input | 8 | Per-element mask bits |
| mask_en_i | input | 1 | Enable masking |
| sew_i | input | 2 | Element width code |
| base_i | input | IDX_W | Index of element 0 of the lane |
| vstart_i | input | IDX_W | First body index |
| vl_i | input | IDX_W | Body end index (exclusive) |
| valid_o | output | 1 | Result valid, one-cycle pulse |
| result_o | output | 64 | Registered result word |

## Verification
On every cycle the assertions check four things. The valid output must be a one-cycle echo of the input valid, and the result must hold between pulses. An empty body or an all-zero mask must return the old word unchanged. A full-width element with a zero amount and no masking must pass its data straight through. The bench scenarios are the only way to show the per-width rotation results, the truncation of amounts, the element boundaries and mixed body, tail and mask patterns. The bench compares these against a bit-level reference model.

// File: rtl/simd_ror_pkg.sv
package simd_ror_pkg;
  localparam int unsigned LANE_W   = 64;
  localparam int unsigned LANE_B   = LANE_W / 8;
  localparam int unsigned N_WIDTHS = 4;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_e;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [LANE_B-1:0] byte_en_t;
endpackage

// File: rtl/simd_ror_elem_rot.sv
module simd_ror_elem_rot #(
  parameter int unsigned EW = 8
) (
  input  logic [EW-1:0] d_i,
  input  logic [EW-1:0] a_i,
  output logic [EW-1:0] r_o
);
  localparam int unsigned SH_W = $clog2(EW);

  logic [SH_W-1:0] sh;
  logic [2*EW-1:0] dbl;

  assign sh  = a_i[SH_W-1:0];
  assign dbl = {d_i, d_i} >> sh;
  assign r_o = dbl[EW-1:0];
endmodule

// File: rtl/simd_ror_rotator.sv
module simd_ror_rotator
  import simd_ror_pkg::*;
(
  input  lane_t       data_i,
  input  lane_t       amt_i,
  input  logic [1:0]  sew_i,
  output lane_t       rot_o
);
  lane_t rot_w [N_WIDTHS];

  for (genvar s = 0; s < N_WIDTHS; s++) begin : g_width
    localparam int unsigned EW = 8 << s;
    localparam int unsigned NE = LANE_W / EW;
    for (genvar e = 0; e < NE; e++) begin : g_elem
      simd_ror_elem_rot #(.EW(EW)) u_rot (
        .d_i (data_i[e*EW +: EW]),
        .a_i (amt_i[e*EW +: EW]),
        .r_o (rot_w[s][e*EW +: EW])
      );
    end
  end

  always_comb begin
    unique case (sew_i)
      EW8:     rot_o = rot_w[0];
      EW16:    rot_o = rot_w[1];
      EW32:    rot_o = rot_w[2];
      default: rot_o = rot_w[3];
    endcase
  end
endmodule

// File: rtl/simd_ror_active.sv
module simd_ror_active
  import simd_ror_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic [LANE_B-1:0] mask_i,
  input  logic              mask_en_i,
  input  logic [1:0]        sew_i,
  input  logic [IDX_W-1:0]  base_i,
  input  logic [IDX_W-1:0]  vstart_i,
  input  logic [IDX_W-1:0]  vl_i,
  output byte_en_t          byte_en_o
);
  localparam int unsigned CMP_W = IDX_W + 1;

  logic [CMP_W-1:0] start_x, end_x;
  byte_en_t         en_w [N_WIDTHS];

  assign start_x = {1'b0, vstart_i};
  assign end_x   = {1'b0, vl_i};

  for (genvar s = 0; s < N_WIDTHS; s++) begin : g_width
    for (genvar b = 0; b < LANE_B; b++) begin : g_byte
      localparam int unsigned ELEM = b >> s;
      logic [CMP_W-1:0] idx;
      logic             in_body;
      assign idx         = {1'b0, base_i} + CMP_W'(ELEM);
      assign in_body     = (idx >= start_x) && (idx < end_x);
      assign en_w[s][b]  = in_body && (!mask_en_i || mask_i[ELEM]);
    end
  end

  always_comb begin
    unique case (sew_i)
      EW8:     byte_en_o = en_w[0];
      EW16:    byte_en_o = en_w[1];
      EW32:    byte_en_o = en_w[2];
      default: byte_en_o = en_w[3];
    endcase
  end
endmodule

// File: rtl/simd_ror.sv
module simd_ror
  import simd_ror_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [63:0]       data_i,
  input  logic [63:0]       amt_i,
  input  logic [63:0]       old_i,
  input  logic [7:0]        mask_i,
  input  logic              mask_en_i,
  input  logic [1:0]        sew_i,
  input  logic [IDX_W-1:0]  base_i,
  input  logic [IDX_W-1:0]  vstart_i,
  input  logic [IDX_W-1:0]  vl_i,
  output logic              valid_o,
  output logic [63:0]       result_o
);
  lane_t    rot;
  lane_t    merged;
  byte_en_t byte_en;

  simd_ror_rotator u_rot (
    .data_i (data_i),
    .amt_i  (amt_i),
    .sew_i  (sew_i),
    .rot_o  (rot)
  );

  simd_ror_active #(.IDX_W(IDX_W)) u_act (
    .mask_i    (mask_i),
    .mask_en_i (mask_en_i),
    .sew_i     (sew_i),
    .base_i    (base_i),
    .vstart_i  (vstart_i),
    .vl_i      (vl_i),
    .byte_en_o (byte_en)
  );

  for (genvar b = 0; b < LANE_B; b++) begin : g_merge
    assign merged[b*8 +: 8] = byte_en[b] ? rot[b*8 +: 8] : old_i[b*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= merged;
    end
  end
endmodule

// File: rtl/simd_ror_chk.sv
module simd_ror_chk #(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [63:0]      data_i,
  input logic [63:0]      amt_i,
  input logic [63:0]      old_i,
  input logic [7:0]       mask_i,
  input logic             mask_en_i,
  input logic [1:0]       sew_i,
  input logic [IDX_W-1:0] base_i,
  input logic [IDX_W-1:0] vstart_i,
  input logic [IDX_W-1:0] vl_i,
  input logic             valid_o,
  input logic [63:0]      result_o
);
  assert_valid_echo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o)));

  assert_empty_body_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (vl_i <= vstart_i)) |=> (result_o == $past(old_i)));

  assert_mask_none_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_en_i && (mask_i == 8'h00)) |=> (result_o == $past(old_i)));

  assert_zero_amt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mask_en_i && (sew_i == 2'd3) && (amt_i[5:0] == 6'd0) &&
     (vstart_i <= base_i) && ({1'b0, base_i} < {1'b0, vl_i}))
    |=> (result_o == $past(data_i)));
endmodule

bind simd_ror simd_ror_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/simd_ror_tb.sv
module simd_ror_tb;
  localparam int IDX_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [63:0]      data_i = '0, amt_i = '0, old_i = '0;
  logic [7:0]       mask_i = '0;
  logic             mask_en_i = 1'b0;
  logic [1:0]       sew_i = '0;
  logic [IDX_W-1:0] base_i = '0, vstart_i = '0, vl_i = '0;
  logic             valid_o;
  logic [63:0]      result_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  simd_ror #(.IDX_W(IDX_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .amt_i(amt_i), .old_i(old_i), .mask_i(mask_i), .mask_en_i(mask_en_i),
    .sew_i(sew_i), .base_i(base_i), .vstart_i(vstart_i), .vl_i(vl_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [63:0] model(
    logic [63:0] d, logic [63:0] a, logic [63:0] o, logic [7:0] m,
    logic men, logic [1:0] sew, int base, int vs, int vl);
    logic [63:0] r;
    int ew, ne, sh, amt, idx;
    r  = o;
    ew = 8 << sew;
    ne = 64 / ew;
    sh = 3 + int'(sew);
    for (int e = 0; e < ne; e++) begin
      idx = base + e;
      if (idx >= vs && idx < vl && (!men || m[e])) begin
        amt = 0;
        for (int k = 0; k < sh; k++) amt = amt | (int'(a[e*ew + k]) << k);
        for (int k = 0; k < ew; k++) r[e*ew + k] = d[e*ew + ((k + amt) % ew)];
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(logic [63:0] d, logic [63:0] a, logic [63:0] o,
                      logic [7:0] m, logic men, logic [1:0] sew,
                      int base, int vs, int vl, string tag);
    @(negedge clk);
    data_i = d; amt_i = a; old_i = o; mask_i = m; mask_en_i = men;
    sew_i = sew; base_i = IDX_W'(base); vstart_i = IDX_W'(vs); vl_i = IDX_W'(vl);
    valid_i = 1'b1;
    exp_q.push_back(model(d, a, o, m, men, sew, base, vs, vl));
    tag_q.push_back(tag);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && valid_o) begin
        if (exp_q.size() == 0) check("R9 unexpected valid", 64'd1, 64'd0);
        else check(tag_q.pop_front(), result_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check("R10 reset valid", {63'd0, valid_o}, 64'd0);
    check("R10 reset result", result_o, 64'd0);
    rst_ni = 1'b1;

    // R1 R4: per-width rotations, full body
    send(64'h0123456789ABCDEF, 64'h0101010101010101, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 1'b0, 2'd0, 0, 0, 8, "R1 ew8 by1");
    send(64'h8001_0001_F00F_1234, 64'h0004_000F_0008_0001, '0, 8'h00, 1'b0, 2'd1, 0, 0, 8, "R4 ew16");
    send(64'hDEADBEEF_00000001, 64'h00000010_0000001F, '0, 8'h00, 1'b0, 2'd2, 0, 0, 8, "R4 ew32");
    send(64'h8000_0000_0000_0001, 64'd63, '0, 8'h00, 1'b0, 2'd3, 0, 0, 8, "R1 ew64 by63");
    check("R1 ew64 by63 direct", model(64'h8000_0000_0000_0001, 64'd63, '0, 8'h00, 1'b0, 2'd3, 0, 0, 8), 64'h0000_0000_0000_0003);
    // R2: data and amount roles distinct
    send(64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0004, '0, 8'h00, 1'b0, 2'd0, 0, 0, 8, "R2 data vs amt");
    // R3: upper amount bits ignored
    send(64'hA5A5_A5A5_A5A5_A5A5, 64'hF9F9_F9F9_F9F9_F9F9, '0, 8'h00, 1'b0, 2'd0, 0, 0, 8, "R3 ew8 trunc");
    send(64'h1234_5678_9ABC_DEF0, 64'hFFF3_0010_0020_7FF5, '0, 8'h00, 1'b0, 2'd1, 0, 0, 8, "R3 ew16 trunc");
    send(64'h0F0F_0F0F_3333_5555, 64'hFFFFFFC1_00000040, '0, 8'h00, 1'b0, 2'd3, 0, 0, 8, "R3 ew64 trunc");
    // R8: zero amount
    send(64'hCAFEBABE_12345678, 64'h00000020_00000040, '0, 8'h00, 1'b0, 2'd2, 0, 0, 8, "R8 zero amt");
    // R5: masking
    send(64'h0102040810204080, 64'h0303030303030303, 64'h1111_2222_3333_4444, 8'h55, 1'b1, 2'd0, 0, 0, 8, "R5 mask alt");
    send(64'h0102040810204080, 64'h0303030303030303, 64'h1111_2222_3333_4444, 8'h55, 1'b0, 2'd0, 0, 0, 8, "R5 mask off");
    send(64'hFFFF_0000_1234_8001, 64'h0001_0001_0001_0001, 64'hAAAA_AAAA_AAAA_AAAA, 8'hF6, 1'b1, 2'd1, 0, 0, 8, "R5 ew16 mask");
    // R6 R7: body bounds with base
    send(64'h0123456789ABCDEF, 64'h0202020202020202, 64'h7777_7777_7777_7777, 8'h00, 1'b0, 2'd0, 16, 18, 22, "R6 vstart vl");
    send(64'h0123456789ABCDEF, 64'h0202020202020202, 64'h7777_7777_7777_7777, 8'h00, 1'b0, 2'd0, 16, 0, 16, "R7 all tail");
    send(64'h0123456789ABCDEF, 64'h0202020202020202, 64'h7777_7777_7777_7777, 8'h00, 1'b0, 2'd2, 8, 9, 10, "R6 ew32 upper");
    send(64'hFEDCBA9876543210, 64'h0000000100000001, 64'h5555_5555_5555_5555, 8'h03, 1'b1, 2'd2, 250, 250, 251, "R6 idx edge");
    send(64'hFEDCBA9876543210, 64'h0000000000000008, 64'h5555_5555_5555_5555, 8'h00, 1'b0, 2'd3, 3, 4, 9, "R7 below start");
    // R9: hold between pulses
    repeat (2) @(negedge clk);
    held = result_o;
    check("R9 valid low", {63'd0, valid_o}, 64'd0);
    data_i = ~data_i; old_i = ~old_i;
    repeat (3) @(negedge clk);
    check("R9 result held", result_o, held);
    // back-to-back
    fork
      begin
        send(64'h00000000000000FF, 64'h0000000000000004, '0, 8'h00, 1'b0, 2'd3, 0, 0, 1, "R9 b2b a");
      end
    join
    send(64'h00000000000000FF, 64'h0000000000000008, '0, 8'h00, 1'b0, 2'd3, 0, 0, 1, "R9 b2b b");
    repeat (3) @(negedge clk);
    check("R9 queue drained", 64'(exp_q.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule